// File: doc/BRIEF.md
# Duty-Cycled Supply Monitor Controller

This block is the digital side of a supply-voltage monitor. An analog comparator, outside the block, reports whether the supply is below a programmable trip level. The controller holds the trip-level code and passes it to the comparator. It turns the comparator on either all the time or for a single slow-clock period out of every 32, 256 or 2048 periods, so the comparator draws power only when a measurement is needed. It captures each measurement into a live status bit and a sticky detection bit. The sticky bit stays set until a status read clears it. A detection can also raise a one-cycle core reset request and a level interrupt.

Software writes one configuration word through a write strobe. It reads status through a read strobe. The status bits are always visible on the outputs, and the read strobe marks the moment of the read, which clears the sticky bit. The whole block runs on the slow clock.

Top module: `smon_ctrl`

## Requirements
- R1: `cmp_thresh` equals the threshold field, `cfg_wdata[3:0]`, of the most recent write, starting the cycle after `cfg_wr`.
- R2: The mode field is `cfg_wdata[6:4]`. Code 0, and codes 5 to 7, disable monitoring. While monitoring is disabled, `cmp_en` stays 0 and `cmp_below` has no effect on any status bit.
- R3: Mode code 1 (continuous) holds `cmp_en` at 1 and makes every cycle a measurement.
- R4: Mode codes 2, 3 and 4 select sampling periods P of 32, 256 and 2048 cycles. A period counter restarts at every configuration write. `cmp_en` is high for exactly one cycle in every P cycles. The first such cycle is the P-th cycle after the write takes effect.
- R5: At the clock edge that ends a measurement cycle, `stat_live` takes the value of `cmp_below`. Outside measurement cycles, `stat_live` holds its value and ignores `cmp_below`.
- R6: A measurement that sees `cmp_below`=1 sets `stat_sticky`. The bit then holds until a read clears it.
- R7: A `stat_rd` pulse clears `stat_sticky` at the next edge. If a below-threshold measurement falls in the same cycle as the read, the bit stays set.
- R8: `cfg_wdata[7]` is the reset enable. When it is set, a below-threshold measurement whose previous measured value was not below raises `core_rst_req` for exactly one cycle, in step with the `stat_live` update.
- R9: `cfg_wdata[8]` is the interrupt enable. `irq` equals the interrupt enable AND `stat_sticky`.
- R10: After reset, all outputs are 0 and monitoring is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | THR_W+5 | Configuration word: threshold, mode, reset enable, interrupt enable |
| stat_rd | input | 1 | Status read strobe; clears the sticky bit |
| stat_live | output | 1 | Result of the latest measurement |
| stat_sticky | output | 1 | Detection seen since the last read |
| cmp_thresh | output | THR_W | Trip-level code sent to the comparator |
| cmp_en | output | 1 | Comparator enable |
| cmp_below | input | 1 | Comparator result: supply below the trip level |
| core_rst_req | output | 1 | One-cycle core reset request |
| irq | output | 1 | Detection interrupt |

## Verification
The hardest case to reach is the 2048-cycle sampling mode interacting with other events. A measurement cycle there comes only once every 2048 cycles. A read has to land exactly on that cycle to test the read/detect collision, and a configuration write has to arrive partway through a period to show the counter restart. The bench runs a directed 2048 segment longer than two periods and a directed collision in continuous mode. A long random run then writes new configurations only rarely, so that long-period modes complete several measurements. During that run, reads and comparator changes occur often, so they fall on measurement cycles. Every cycle is compared against a reference model built from the requirements.

// File: rtl/smon_pkg.sv
package smon_pkg;

    typedef enum logic [2:0] {
        SM_OFF   = 3'd0,
        SM_CONT  = 3'd1,
        SM_P32   = 3'd2,
        SM_P256  = 3'd3,
        SM_P2048 = 3'd4
    } smon_mode_e;

    function automatic smon_mode_e smon_norm_mode(logic [2:0] raw);
        smon_mode_e m;
        case (raw)
            3'd1:    m = SM_CONT;
            3'd2:    m = SM_P32;
            3'd3:    m = SM_P256;
            3'd4:    m = SM_P2048;
            default: m = SM_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/smon_cfg.sv
module smon_cfg
    import smon_pkg::*;
#(
    parameter int THR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [THR_W+4:0]     wdata,
    output logic [THR_W-1:0]     thr,
    output smon_mode_e           mode,
    output logic                 rst_en,
    output logic                 irq_en
);
    localparam int MODE_LSB = THR_W;
    localparam int RSTE_BIT = THR_W + 3;
    localparam int IRQE_BIT = THR_W + 4;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        smon_mode_e       mode;
        logic             rst_en;
        logic             irq_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.thr    = wdata[THR_W-1:0];
            cfg_d.mode   = smon_norm_mode(wdata[MODE_LSB+2:MODE_LSB]);
            cfg_d.rst_en = wdata[RSTE_BIT];
            cfg_d.irq_en = wdata[IRQE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{thr: '0, mode: SM_OFF, rst_en: 1'b0, irq_en: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign thr    = cfg_q.thr;
    assign mode   = cfg_q.mode;
    assign rst_en = cfg_q.rst_en;
    assign irq_en = cfg_q.irq_en;

endmodule

// File: rtl/smon_sched.sv
module smon_sched
    import smon_pkg::*;
#(
    parameter int SH_A = 5,
    parameter int SH_B = 8,
    parameter int SH_C = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  smon_mode_e mode,
    output logic       meas_en
);
    localparam int CNT_W = SH_C;
    localparam logic [CNT_W-1:0] MASK_A = CNT_W'((1 << SH_A) - 1);
    localparam logic [CNT_W-1:0] MASK_B = CNT_W'((1 << SH_B) - 1);
    localparam logic [CNT_W-1:0] MASK_C = CNT_W'((1 << SH_C) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } sched_t;

    sched_t st_d, st_q;
    logic [CNT_W-1:0] mask;
    logic             sampled;
    logic             hit;

    always_comb begin
        sampled = 1'b1;
        case (mode)
            SM_P32:   mask = MASK_A;
            SM_P256:  mask = MASK_B;
            SM_P2048: mask = MASK_C;
            default: begin
                mask    = '0;
                sampled = 1'b0;
            end
        endcase
        hit     = ((st_q.cnt & mask) == mask);
        meas_en = (mode == SM_CONT) || (sampled && hit);
    end

    always_comb begin
        st_d = st_q;
        if (clr) st_d.cnt = '0;
        else     st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    // One enabled cycle per period in the sampled modes
    assert_single_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sampled && meas_en && !clr) |=> !meas_en);

    // A restart leaves the comparator off in the following cycle unless continuous
    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!meas_en || mode == SM_CONT));

endmodule

// File: rtl/smon_status.sv
module smon_status (
    input  logic clk,
    input  logic rst_n,
    input  logic meas,
    input  logic below,
    input  logic rd,
    input  logic rst_en,
    input  logic irq_en,
    output logic live,
    output logic sticky,
    output logic rst_req,
    output logic irq
);
    typedef struct packed {
        logic live;
        logic sticky;
        logic rst_req;
    } stat_t;

    stat_t st_d, st_q;
    logic  detect;

    always_comb begin
        detect     = meas && below;
        st_d       = st_q;
        if (meas) st_d.live = below;
        st_d.sticky  = (st_q.sticky && !rd) || detect;
        st_d.rst_req = rst_en && detect && !st_q.live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{live: 1'b0, sticky: 1'b0, rst_req: 1'b0};
        else        st_q <= st_d;
    end

    assign live    = st_q.live;
    assign sticky  = st_q.sticky;
    assign rst_req = st_q.rst_req;
    assign irq     = irq_en && st_q.sticky;

    assert_live_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !meas |=> $stable(live));

    assert_sticky_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        detect |=> sticky);

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !detect) |=> !sticky);

    assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sticky);

endmodule

// File: rtl/smon_ctrl.sv
module smon_ctrl
    import smon_pkg::*;
#(
    parameter int THR_W = 4,
    parameter int SH_A  = 5,
    parameter int SH_B  = 8,
    parameter int SH_C  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [THR_W+4:0] cfg_wdata,
    input  logic             stat_rd,
    output logic             stat_live,
    output logic             stat_sticky,
    output logic [THR_W-1:0] cmp_thresh,
    output logic             cmp_en,
    input  logic             cmp_below,
    output logic             core_rst_req,
    output logic             irq
);
    smon_mode_e mode;
    logic       rst_en;
    logic       irq_en;

    smon_cfg #(.THR_W(THR_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wdata  (cfg_wdata),
        .thr    (cmp_thresh),
        .mode   (mode),
        .rst_en (rst_en),
        .irq_en (irq_en)
    );

    smon_sched #(.SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_wr),
        .mode    (mode),
        .meas_en (cmp_en)
    );

    smon_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .meas    (cmp_en),
        .below   (cmp_below),
        .rd      (stat_rd),
        .rst_en  (rst_en),
        .irq_en  (irq_en),
        .live    (stat_live),
        .sticky  (stat_sticky),
        .rst_req (core_rst_req),
        .irq     (irq)
    );

    assert_thresh_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cmp_thresh == $past(cfg_wdata[THR_W-1:0])));

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_OFF) |-> !cmp_en);

    assert_cont_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_CONT) |-> cmp_en);

    assert_no_reset_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_en |=> !core_rst_req);

endmodule

// File: tb/tb_smon_ctrl.sv
module tb_smon_ctrl;
    localparam int THR_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [THR_W+4:0] cfg_wdata = '0;
    logic             stat_rd = 1'b0;
    logic             cmp_below = 1'b0;
    logic             stat_live, stat_sticky, cmp_en, core_rst_req, irq;
    logic [THR_W-1:0] cmp_thresh;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [THR_W-1:0] m_thr = '0;
    logic [2:0]       m_mode = 3'd0;
    logic             m_rste = 1'b0, m_irqe = 1'b0;
    logic [10:0]      m_cnt = '0;
    logic             m_live = 1'b0, m_sticky = 1'b0, m_rreq = 1'b0;

    always #10 clk = ~clk;

    smon_ctrl #(.THR_W(THR_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .stat_rd(stat_rd), .stat_live(stat_live), .stat_sticky(stat_sticky),
        .cmp_thresh(cmp_thresh), .cmp_en(cmp_en), .cmp_below(cmp_below),
        .core_rst_req(core_rst_req), .irq(irq)
    );

    function automatic logic [THR_W+4:0] cfgw(logic [3:0] thr, logic [2:0] md,
                                              logic re, logic ie);
        return {ie, re, md, thr};
    endfunction

    function automatic logic exp_en(logic [2:0] md, logic [10:0] c);
        logic [10:0] mk;
        case (md)
            3'd1: return 1'b1;
            3'd2: mk = 11'd31;
            3'd3: mk = 11'd255;
            3'd4: mk = 11'd2047;
            default: return 1'b0;
        endcase
        return (c & mk) == mk;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic e;
        e = exp_en(m_mode, m_cnt);
        if (m_mode == 3'd1)                       chk("R3 cmp_en", cmp_en, e);
        else if (m_mode >= 3'd2 && m_mode <= 3'd4) chk("R4 cmp_en", cmp_en, e);
        else                                      chk("R2 cmp_en", cmp_en, e);
        chk("R1 thresh", cmp_thresh, m_thr);
        chk("R5 live", stat_live, m_live);
        chk("R6 sticky", stat_sticky, m_sticky);
        chk("R8 rst_req", core_rst_req, m_rreq);
        chk("R9 irq", irq, m_irqe & m_sticky);
    endtask

    // called at negedge with inputs set; advances one cycle and checks
    task automatic step(logic wr, logic [THR_W+4:0] wd, logic rd, logic below);
        logic meas, ev;
        cfg_wr = wr; cfg_wdata = wd; stat_rd = rd; cmp_below = below;
        @(posedge clk);
        meas = exp_en(m_mode, m_cnt);
        ev = meas && below;
        m_rreq = m_rste && ev && !m_live;
        m_sticky = (m_sticky && !rd) || ev;
        if (meas) m_live = below;
        if (wr) begin
            m_thr = wd[3:0];
            m_mode = wd[6:4];
            m_rste = wd[7];
            m_irqe = wd[8];
            m_cnt = '0;
        end else begin
            m_cnt = m_cnt + 11'd1;
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(20 * 190000);
        failures++;
        $display("FAIL R4 watchdog: actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic b;
        int seed;
        int first_en;
        seed = 32'h5A17;
        b = $urandom(seed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 live", stat_live, 1'b0);
        chk("R10 sticky", stat_sticky, 1'b0);
        chk("R10 cmp_en", cmp_en, 1'b0);
        chk("R10 rst_req", core_rst_req, 1'b0);
        chk("R10 irq", irq, 1'b0);
        chk("R10 thresh", cmp_thresh, 0);

        // R2: disabled, below ignored
        repeat (40) step(0, '0, 0, 1);
        chk("R2 sticky untouched", stat_sticky, 1'b0);
        step(1, cfgw(4'h6, 3'd6, 1, 1), 0, 1);
        repeat (40) step(0, '0, 0, 1);
        chk("R2 invalid mode live", stat_live, 1'b0);

        // R3, R8, R7 in continuous mode
        step(1, cfgw(4'h3, 3'd1, 1, 1), 0, 0);
        step(0, '0, 0, 1);
        chk("R8 pulse", core_rst_req, 1'b1);
        step(0, '0, 1, 1);
        chk("R7 collision keeps sticky", stat_sticky, 1'b1);
        chk("R8 no repeat", core_rst_req, 1'b0);
        step(0, '0, 1, 0);
        chk("R7 read clears", stat_sticky, 1'b0);
        repeat (20) step(0, '0, 0, 0);

        // R4: 32-period, first enable on 32nd cycle after write
        step(1, cfgw(4'h9, 3'd2, 1, 0), 0, 1);
        first_en = -1;
        for (int i = 0; i < 100; i++) begin
            if (cmp_en && first_en < 0) first_en = i;
            step(0, '0, 0, 1);
        end
        chk("R4 first enable offset", first_en, 31);
        chk("R9 irq disabled", irq, 1'b0);

        // R4/R5: mid-period restart then 256 and 2048 modes
        step(1, cfgw(4'h2, 3'd3, 0, 1), 1, 0);
        repeat (600) step(0, '0, 0, 0);
        step(1, cfgw(4'hF, 3'd4, 1, 1), 0, 0);
        repeat (3000) step(0, '0, 0, 0);
        step(1, cfgw(4'hF, 3'd4, 1, 1), 0, 1);
        repeat (4200) step(0, '0, ($urandom % 64) == 0, 1);

        // constrained random
        b = 1'b0;
        for (int i = 0; i < 150000; i++) begin
            logic w;
            if (($urandom % 8) == 0) b = ~b;
            w = ($urandom % 3000) == 0;
            step(w, cfgw(4'($urandom), 3'($urandom % 8), 1'($urandom), 1'($urandom)),
                 ($urandom % 16) == 0, b);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule